// File: doc/BRIEF.md
# Chip Erase Retry Sequencer

This controller runs the blank-until-clean erase procedure for an electrically erasable EPROM. It does not generate any voltage. It drives enables that select the supply levels, and it drives the control strobes, the address bus and the data bus of the memory. A run begins with a single-cycle start. The sequencer first raises the high programming voltage and the high-voltage enable on address pin 9. It holds every address bit low, drives all data bits high, and applies one long program strobe with chip enable low and output enable high.

After each strobe, the high-voltage enables fall and the reduced verify supply is selected. The sequencer then reads the array from address zero upward and compares each byte against all ones. The first byte that is not blank ends that scan. When this happens, another erase pulse follows unless the pulse limit has been reached. If a scan reaches the last address with every byte blank, the run passes. When the run ends, the sequencer raises done for one cycle. It then holds pass or fail, the number of pulses applied, and the most recent non-blank address until the next start.

Every duration is a parameter counted in clock cycles: supply settle, strobe setup, pulse width, address hold and read access. The integrator chooses these values to meet the analogue timing limits at the chosen clock.

Top module: `erase_seq`

## Requirements
- R1: During and after reset, the device pins rest at their idle levels. Chip enable, output enable and program strobe are high (inactive). The high programming voltage, address-9 high-voltage and reduced-supply enables are low. The data bus is not driven and reads as 0. Busy, done, pass and fail are low, and the pulse count and recorded address are 0.
- R2: Start is taken only while the sequencer is idle. Start pulses while busy or during the done cycle have no effect on any output. Accepting start clears pass, fail, the pulse count and the recorded address, and raises busy in the next cycle.
- R3: While the program strobe is low, the following all hold: the high programming voltage enable is high, the address-9 high-voltage enable is high, chip enable is low, output enable is high, the address is all zeros, the data bus is driven to all ones, and the reduced-supply enable is low.
- R4: Each erase attempt runs through four phases in order. First, SETTLE_CYC cycles with the high-voltage enables on and the strobe high. Next, SETUP_CYC more cycles in the same state. Then the strobe goes low for exactly PULSE_CYC cycles. Finally, HOLD_CYC cycles follow with the strobe high and the address and high-voltage enables unchanged.
- R5: After the hold, the high-voltage enables fall and the reduced-supply enable rises. Chip enable and output enable go low and the data bus is released. SETTLE_CYC cycles then pass before the first read address is used.
- R6: The verify scan presents addresses 0, 1, 2 … in ascending order, each for READ_CYC cycles. The read data is judged in the last cycle of each address, and a byte is blank only when every bit is 1.
- R7: The scan stops at the first non-blank byte of a pass. That address appears on fail_addr from the next cycle and stays there through later passes until another mismatch replaces it or a start clears it.
- R8: pulse_cnt rises by one at the end of each erase strobe. After a mismatch with fewer than MAX_PULSES pulses applied, the sequencer starts a new attempt at the R4 settle phase with the address back at 0.
- R9: A mismatch found when MAX_PULSES pulses have been applied ends the run with fail high, pass low and pulse_cnt equal to MAX_PULSES.
- R10: A scan in which all 2^AW bytes are blank ends the run with pass high, fail low and pulse_cnt equal to the number of pulses applied.
- R11: When the run ends, done is high for exactly one cycle while busy is already low, and all pins return to idle levels. Pass, fail, pulse_cnt and fail_addr then stay constant until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, honoured only when idle |
| din | input | DW | Data read from the memory |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run flag |
| pass | output | 1 | Run ended with a blank array |
| fail | output | 1 | Run ended at the pulse limit |
| pulse_cnt | output | $clog2(MAX_PULSES+1) | Erase pulses applied in this run |
| fail_addr | output | AW | Latest address found non-blank |
| dev_addr | output | AW | Memory address bus |
| dev_dout | output | DW | Data driven to the memory |
| dev_dout_en | output | 1 | Data bus drive enable |
| dev_ce_n | output | 1 | Chip enable, active low |
| dev_oe_n | output | 1 | Output enable, active low |
| dev_pgm_n | output | 1 | Program strobe, active low |
| vpp_hi_en | output | 1 | Select high programming voltage |
| a9_hv_en | output | 1 | Select high voltage on address pin 9 |
| low_sup_en | output | 1 | Select reduced verify supply on both rails |

## Verification
Every output is registered from the next-state decode. Because of this, a wrong phase, a timer that is off by one, or a skipped address shows on the device pins in the same cycle it occurs. The bench compares those pins against a behavioural timeline on every clock. A wrong pulse count or a wrong retry decision first appears on pulse_cnt at the end of a strobe. It also shows as an extra or missing settle phase at most one scan later. A scan that does not stop at the first non-blank byte, or that latches a different address, is visible on dev_addr in the very next cycle and on fail_addr at the same edge.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ER_SETTLE,
    ST_ER_SETUP,
    ST_PULSE,
    ST_ER_HOLD,
    ST_VF_SETTLE,
    ST_READ,
    ST_DONE
  } es_state_t;

  typedef struct packed {
    logic vpp_hi;
    logic a9_hv;
    logic low_sup;
    logic ce_n;
    logic oe_n;
    logic pgm_n;
    logic drv;
  } pin_ctl_t;

  // Pin levels belonging to each sequencer phase.
  function automatic pin_ctl_t pins_for(es_state_t s);
    pin_ctl_t p;
    p = '{vpp_hi: 1'b0, a9_hv: 1'b0, low_sup: 1'b0,
          ce_n: 1'b1, oe_n: 1'b1, pgm_n: 1'b1, drv: 1'b0};
    case (s)
      ST_ER_SETTLE, ST_ER_SETUP, ST_ER_HOLD: begin
        p.vpp_hi = 1'b1;
        p.a9_hv  = 1'b1;
        p.ce_n   = 1'b0;
        p.drv    = 1'b1;
      end
      ST_PULSE: begin
        p.vpp_hi = 1'b1;
        p.a9_hv  = 1'b1;
        p.ce_n   = 1'b0;
        p.drv    = 1'b1;
        p.pgm_n  = 1'b0;
      end
      ST_VF_SETTLE, ST_READ: begin
        p.low_sup = 1'b1;
        p.ce_n    = 1'b0;
        p.oe_n    = 1'b0;
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/erase_seq_timer.sv
module erase_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/erase_seq_scan.sv
module erase_seq_scan #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      addr <= '0;
    else if (inc)
      addr <= addr + 1'b1;
  end

  assign last = (addr == {AW{1'b1}});
endmodule

// File: rtl/erase_seq_tally.sv
module erase_seq_tally #(
  parameter int MAX_PULSES = 20,
  parameter int CW         = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          at_limit
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (inc)
      count <= count + 1'b1;
  end

  assign at_limit = (count == CW'(MAX_PULSES));
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int AW         = 17,
  parameter int DW         = 8,
  parameter int MAX_PULSES = 20,
  parameter int PULSE_CYC  = 12_500_000,
  parameter int SETTLE_CYC = 1250,
  parameter int SETUP_CYC  = 250,
  parameter int HOLD_CYC   = 250,
  parameter int READ_CYC   = 10,
  localparam int CW        = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] din,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [CW-1:0] pulse_cnt,
  output logic [AW-1:0] fail_addr,
  output logic [AW-1:0] dev_addr,
  output logic [DW-1:0] dev_dout,
  output logic          dev_dout_en,
  output logic          dev_ce_n,
  output logic          dev_oe_n,
  output logic          dev_pgm_n,
  output logic          vpp_hi_en,
  output logic          a9_hv_en,
  output logic          low_sup_en
);
  localparam int M1   = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int M2   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int M3   = (M2 > READ_CYC) ? M2 : READ_CYC;
  localparam int TMAX = (M1 > M3) ? M1 : M3;
  localparam int TW   = $clog2(TMAX + 1);

  localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] T_SETUP  = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] T_PULSE  = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] T_HOLD   = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] T_READ   = TW'(READ_CYC - 1);

  es_state_t     st_q, st_nxt;
  pin_ctl_t      pin_q, pin_nxt;
  logic          t_load, t_exp;
  logic [TW-1:0] t_val;
  logic          a_clr, a_inc, a_last;
  logic          p_clr, p_inc, p_lim;
  logic          accept, res_pass, res_fail, rec_addr;
  logic          byte_blank;
  logic [AW-1:0] scan_addr;

  erase_seq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  erase_seq_scan #(.AW(AW)) u_scan (
    .clk(clk), .rst(rst), .clr(a_clr), .inc(a_inc),
    .addr(scan_addr), .last(a_last)
  );

  erase_seq_tally #(.MAX_PULSES(MAX_PULSES), .CW(CW)) u_tally (
    .clk(clk), .rst(rst), .clr(p_clr), .inc(p_inc),
    .count(pulse_cnt), .at_limit(p_lim)
  );

  assign byte_blank = (din == {DW{1'b1}});

  always_comb begin
    st_nxt   = st_q;
    t_load   = 1'b0;
    t_val    = '0;
    a_clr    = 1'b0;
    a_inc    = 1'b0;
    p_clr    = 1'b0;
    p_inc    = 1'b0;
    accept   = 1'b0;
    res_pass = 1'b0;
    res_fail = 1'b0;
    rec_addr = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        accept = 1'b1;
        st_nxt = ST_ER_SETTLE;
        t_load = 1'b1;
        t_val  = T_SETTLE;
        a_clr  = 1'b1;
        p_clr  = 1'b1;
      end
      ST_ER_SETTLE: if (t_exp) begin
        st_nxt = ST_ER_SETUP;
        t_load = 1'b1;
        t_val  = T_SETUP;
      end
      ST_ER_SETUP: if (t_exp) begin
        st_nxt = ST_PULSE;
        t_load = 1'b1;
        t_val  = T_PULSE;
      end
      ST_PULSE: if (t_exp) begin
        st_nxt = ST_ER_HOLD;
        t_load = 1'b1;
        t_val  = T_HOLD;
        p_inc  = 1'b1;
      end
      ST_ER_HOLD: if (t_exp) begin
        st_nxt = ST_VF_SETTLE;
        t_load = 1'b1;
        t_val  = T_SETTLE;
      end
      ST_VF_SETTLE: if (t_exp) begin
        st_nxt = ST_READ;
        t_load = 1'b1;
        t_val  = T_READ;
      end
      ST_READ: if (t_exp) begin
        if (byte_blank) begin
          if (a_last) begin
            st_nxt   = ST_DONE;
            res_pass = 1'b1;
          end else begin
            a_inc  = 1'b1;
            t_load = 1'b1;
            t_val  = T_READ;
          end
        end else begin
          rec_addr = 1'b1;
          if (p_lim) begin
            st_nxt   = ST_DONE;
            res_fail = 1'b1;
          end else begin
            st_nxt = ST_ER_SETTLE;
            t_load = 1'b1;
            t_val  = T_SETTLE;
            a_clr  = 1'b1;
          end
        end
      end
      ST_DONE: st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign pin_nxt = pins_for(st_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      pin_q     <= pins_for(ST_IDLE);
      busy      <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      dev_dout  <= '0;
    end else begin
      st_q     <= st_nxt;
      pin_q    <= pin_nxt;
      busy     <= (st_nxt != ST_IDLE) && (st_nxt != ST_DONE);
      done     <= (st_nxt == ST_DONE);
      dev_dout <= pin_nxt.drv ? {DW{1'b1}} : {DW{1'b0}};
      if (accept) begin
        pass      <= 1'b0;
        fail      <= 1'b0;
        fail_addr <= '0;
      end else begin
        if (res_pass) pass <= 1'b1;
        if (res_fail) fail <= 1'b1;
        if (rec_addr) fail_addr <= scan_addr;
      end
    end
  end

  assign dev_addr    = scan_addr;
  assign dev_dout_en = pin_q.drv;
  assign dev_ce_n    = pin_q.ce_n;
  assign dev_oe_n    = pin_q.oe_n;
  assign dev_pgm_n   = pin_q.pgm_n;
  assign vpp_hi_en   = pin_q.vpp_hi;
  assign a9_hv_en    = pin_q.a9_hv;
  assign low_sup_en  = pin_q.low_sup;
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
  parameter int AW        = 17,
  parameter int CW        = 5,
  parameter int PULSE_CYC = 12_500_000
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic [CW-1:0] pulse_cnt,
  input logic [AW-1:0] dev_addr,
  input logic          dev_dout_en,
  input logic          dev_ce_n,
  input logic          dev_oe_n,
  input logic          dev_pgm_n,
  input logic          vpp_hi_en,
  input logic          a9_hv_en,
  input logic          low_sup_en
);
  localparam int LW = $clog2(PULSE_CYC + 2);
  logic [LW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || dev_pgm_n)
      low_run <= '0;
    else
      low_run <= low_run + 1'b1;
  end

  // R3
  strobe_levels_chk: assert property (@(posedge clk) disable iff (rst)
    !dev_pgm_n |-> (vpp_hi_en && a9_hv_en && !dev_ce_n && dev_oe_n &&
                    dev_addr == '0 && dev_dout_en && !low_sup_en));

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_pgm_n) |-> (low_run == LW'(PULSE_CYC)));

  // R5
  verify_levels_chk: assert property (@(posedge clk) disable iff (rst)
    !dev_oe_n |-> (!dev_ce_n && dev_pgm_n && !dev_dout_en && low_sup_en &&
                   !vpp_hi_en && !a9_hv_en));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (pulse_cnt == $past(pulse_cnt) ||
              pulse_cnt == $past(pulse_cnt) + 1'b1));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done && !start) |=> ($stable(pass) && $stable(fail) &&
                                    $stable(pulse_cnt)));

  // R9
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));
endmodule

bind erase_seq erase_seq_chk #(
  .AW(AW), .CW(CW), .PULSE_CYC(PULSE_CYC)
) u_erase_seq_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .pass(pass), .fail(fail), .pulse_cnt(pulse_cnt), .dev_addr(dev_addr),
  .dev_dout_en(dev_dout_en), .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n),
  .dev_pgm_n(dev_pgm_n), .vpp_hi_en(vpp_hi_en), .a9_hv_en(a9_hv_en),
  .low_sup_en(low_sup_en)
);

// File: tb/erase_seq_bench.sv
`timescale 1ns/1ps
module erase_seq_bench;
  localparam int AW = 4, DW = 8, MAXP = 20;
  localparam int PULSE = 6, SETTLE = 3, SETUP = 2, HOLD = 2, READ = 2;
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(MAXP + 1);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [DW-1:0] din;
  logic busy, done, pass, fail, dout_en, ce_n, oe_n, pgm_n, vpp, a9, lowsup;
  logic [CW-1:0] pulse_cnt;
  logic [AW-1:0] fail_addr, dev_addr;
  logic [DW-1:0] dout;

  int checks = 0, errors = 0, cycles = 0;
  int need [DEPTH];
  int dev_pulses = 0, base = 0;
  logic prev_pgm = 1'b1;
  bit   model_on = 1'b0;

  always #4 clk = ~clk;

  erase_seq #(.AW(AW), .DW(DW), .MAX_PULSES(MAXP), .PULSE_CYC(PULSE),
              .SETTLE_CYC(SETTLE), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD),
              .READ_CYC(READ)) u_erase_seq (
    .clk(clk), .rst(rst), .start(start), .din(din), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .pulse_cnt(pulse_cnt), .fail_addr(fail_addr),
    .dev_addr(dev_addr), .dev_dout(dout), .dev_dout_en(dout_en),
    .dev_ce_n(ce_n), .dev_oe_n(oe_n), .dev_pgm_n(pgm_n), .vpp_hi_en(vpp),
    .a9_hv_en(a9), .low_sup_en(lowsup)
  );

  function automatic logic [DW-1:0] dev_byte(int a, int p);
    return (p >= need[a]) ? 8'hFF : (8'h3C ^ 8'(a));
  endfunction

  // Memory model: a cell reads blank once enough strobes have been seen.
  always @(posedge clk) begin
    prev_pgm <= pgm_n;
    if (pgm_n && !prev_pgm) dev_pulses <= dev_pulses + 1;
  end
  assign din = dev_byte(int'(dev_addr), dev_pulses - base);

  // Expected port values, set by the behavioural timeline.
  logic m_vpp, m_a9, m_low, m_ce, m_oe, m_pgm, m_drv, m_busy, m_done;
  logic m_pass, m_fail;
  int   m_cnt, m_faddr, m_addr;

  task automatic lv(logic v, logic h, logic l, logic c, logic o, logic p,
                    logic d);
    m_vpp = v; m_a9 = h; m_low = l; m_ce = c; m_oe = o; m_pgm = p; m_drv = d;
  endtask

  task automatic run_model();
    bit ok;
    m_pass = 0; m_fail = 0; m_cnt = 0; m_faddr = 0; m_busy = 1; m_done = 0;
    ok = 0;
    forever begin
      lv(1, 1, 0, 0, 1, 1, 1); m_addr = 0;
      repeat (SETTLE) @(posedge clk);
      repeat (SETUP) @(posedge clk);
      lv(1, 1, 0, 0, 1, 0, 1);
      repeat (PULSE) @(posedge clk);
      m_cnt++;
      lv(1, 1, 0, 0, 1, 1, 1);
      repeat (HOLD) @(posedge clk);
      lv(0, 0, 1, 0, 0, 1, 0);
      repeat (SETTLE) @(posedge clk);
      ok = 1;
      for (int a = 0; a < DEPTH; a++) begin
        m_addr = a;
        repeat (READ) @(posedge clk);
        if (dev_byte(a, m_cnt) != 8'hFF) begin
          ok = 0; m_faddr = a;
          break;
        end
      end
      if (ok || m_cnt == MAXP) break;
    end
    lv(0, 0, 0, 1, 1, 1, 0);
    m_busy = 0; m_done = 1; m_pass = ok; m_fail = !ok;
    @(posedge clk);
    m_done = 0;
  endtask

  initial begin
    lv(0, 0, 0, 1, 1, 1, 0);
    m_busy = 0; m_done = 0; m_pass = 0; m_fail = 0;
    m_cnt = 0; m_faddr = 0; m_addr = 0;
    forever begin
      @(posedge clk);
      if (!rst && start) run_model();
    end
  end

  task automatic cmp(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, nm, act,
               exp, $time);
    end
  endtask

  // Per-cycle comparison against the timeline.
  always @(negedge clk) begin
    if (model_on) begin
      cmp("R4", "vpp_hi_en", vpp, m_vpp);
      cmp("R4", "a9_hv_en", a9, m_a9);
      cmp("R4", "dev_pgm_n", pgm_n, m_pgm);
      cmp("R5", "low_sup_en", lowsup, m_low);
      cmp("R5", "dev_ce_n", ce_n, m_ce);
      cmp("R5", "dev_oe_n", oe_n, m_oe);
      cmp("R3", "dev_dout_en", dout_en, m_drv);
      cmp("R3", "dev_dout", dout, m_drv ? 8'hFF : 8'h00);
      cmp("R6", "dev_addr", dev_addr, m_addr);
      cmp("R2", "busy", busy, m_busy);
      cmp("R11", "done", done, m_done);
      cmp("R10", "pass", pass, m_pass);
      cmp("R9", "fail", fail, m_fail);
      cmp("R8", "pulse_cnt", pulse_cnt, m_cnt);
      cmp("R7", "fail_addr", fail_addr, m_faddr);
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_scn(int hold_start);
    base = dev_pulses;
    @(negedge clk); start = 1'b1;
    repeat (hold_start) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle levels under reset
    cmp("R1", "busy", busy, 0);
    cmp("R1", "done", done, 0);
    cmp("R1", "pins", {ce_n, oe_n, pgm_n, vpp, a9, lowsup, dout_en}, 7'b1110000);
    cmp("R1", "dout", dout, 0);
    cmp("R1", "pulse_cnt", pulse_cnt, 0);
    rst = 1'b0;
    model_on = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R1", "pass_fail", {pass, fail}, 0);

    // R10: one pulse blanks the whole array
    foreach (need[i]) need[i] = 1;
    run_scn(1);
    cmp("R10", "pass", pass, 1);
    cmp("R10", "pulse_cnt", pulse_cnt, 1);

    // R7 R8: slow cells at 5 and 9 need extra pulses
    foreach (need[i]) need[i] = 1;
    need[5] = 2; need[9] = 3;
    run_scn(1);
    cmp("R8", "pulse_cnt", pulse_cnt, 3);
    cmp("R7", "fail_addr", fail_addr, 9);
    cmp("R10", "pass", pass, 1);

    // R9: last cell never erases
    foreach (need[i]) need[i] = 1;
    need[DEPTH-1] = 1000;
    run_scn(1);
    cmp("R9", "fail", fail, 1);
    cmp("R9", "pass", pass, 0);
    cmp("R9", "pulse_cnt", pulse_cnt, MAXP);
    cmp("R7", "fail_addr", fail_addr, DEPTH - 1);
    // R11: results held while idle
    repeat (10) @(negedge clk);
    cmp("R11", "fail_held", fail, 1);
    cmp("R11", "cnt_held", pulse_cnt, MAXP);

    // R2: start held well into the run is not re-taken
    foreach (need[i]) need[i] = 2;
    run_scn(30);
    cmp("R2", "pass", pass, 1);
    cmp("R2", "pulse_cnt", pulse_cnt, 2);
    cmp("R7", "fail_addr", fail_addr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule